// File: doc/BRIEF.md
# Periodic Interval Timer with Interrupt

The block is a 24-bit down-counter clocked by the system clock. Software programs a reload value and starts the counter. The counter then counts down to zero, reloads itself and continues. Each time it reaches zero (terminal count), the block can signal an interrupt on an active-low output. The reload value sets the interval: a reload value of N gives one terminal count every N+1 clocks.

The interrupt has two styles, chosen by a control bit:
- **Pulse:** the output goes low for one clock at each terminal count.
- **Handshake:** the output goes low at a terminal count and stays low until software writes the acknowledge address.

A separate enable bit gates the interrupt output. Address decoding for chip selection and privilege checking are done outside the block. The block sees only a word-wide write port and a read port with a two-bit address.

Register addresses:
- **Address 0:** the reload value. It is written and read back in bits 23..0.
- **Address 1:** control. Bit 0 is *run*, bit 1 is *interrupt enable*, bit 2 is *handshake mode* (0 = pulse). Reads return these three bits with zeros above.
- **Address 2:** on a write, it is the acknowledge strobe and the data is ignored. On a read, it returns the live count.
- **Address 3:** reserved. Writes are ignored and reads return zero.

Top module: `hbt_top`

## Requirements
- R1: After reset, irq_n is 1, the reload value is 0, the control bits are 0 and the count reads 0.
- R2: A write to address 0 stores all 24 data bits as the reload value, and reading address 0 returns them.
- R3: A control write that sets run (bit 0) while the counter is stopped loads the count from the reload value at that clock edge. While run is 0 the count does not change.
- R4: While running and not at zero, the count goes down by exactly one at every clock.
- R5: While running, a count of zero is the terminal count. At the next edge the count takes the reload value, so with reload N the terminal count repeats every N+1 clocks.
- R6: irq_n is active low. It never goes low in the clock after a cycle in which interrupt enable (control bit 1) was 0.
- R7: In pulse mode (control bit 2 = 0), irq_n is low in exactly the clock after each terminal count and high otherwise.
- R8: In handshake mode (control bit 2 = 1), irq_n goes low after a terminal count and stays low until a write to address 2. An acknowledge in the same cycle as a terminal count leaves it low.
- R9: A write to address 3 changes neither the reload value, the control bits, the count sequence nor irq_n.
- R10: Clearing interrupt enable while irq_n is low releases it to 1 at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 24 | Read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets reload value 0, where every running clock is a terminal count. A design that asserted a pulse only on edges would leave irq_n high between counts instead of holding it low. It also aims acknowledge writes at the exact cycle of a terminal count; a design that gave the acknowledge priority would lose that interrupt. Starting, stopping and re-setting run while already running are mixed at random, which exposes a reload-on-every-run-write error or a counter that drifts while stopped. Writes to the reserved address and enable toggles while the interrupt is held low catch wrong decoding and a stuck output.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  typedef enum logic [1:0] {
    ADR_RELOAD = 2'd0,
    ADR_CTRL   = 2'd1,
    ADR_ACK    = 2'd2,
    ADR_SPARE  = 2'd3
  } hbt_addr_e;

  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_EN_BIT  = 1;
  localparam int CTL_HS_BIT  = 2;
  localparam int CTL_BITS    = 3;

  // next interrupt level from the present level and this cycle's events
  function automatic logic irq_next(input logic en, input logic hs,
                                    input logic tc, input logic ack,
                                    input logic cur);
    logic held;
    held = hs & cur & ~ack;
    return en & (tc | held);
  endfunction
endpackage

// File: rtl/hbt_regs.sv
module hbt_regs #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  input  logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         run,
  output logic         irq_en,
  output logic         hs_mode,
  output logic         start,
  output logic         ack,
  output logic [W-1:0] rd_data
);
  import hbt_pkg::*;

  localparam int PAD_W = W - CTL_BITS;

  logic wr_reload, wr_ctrl;

  assign wr_reload = wr_en && (wr_addr == ADR_RELOAD);
  assign wr_ctrl   = wr_en && (wr_addr == ADR_CTRL);
  assign ack       = wr_en && (wr_addr == ADR_ACK);
  assign start     = wr_ctrl && wr_data[CTL_RUN_BIT] && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload  <= '0;
      run     <= 1'b0;
      irq_en  <= 1'b0;
      hs_mode <= 1'b0;
    end else begin
      if (wr_reload) reload <= wr_data;
      if (wr_ctrl) begin
        run     <= wr_data[CTL_RUN_BIT];
        irq_en  <= wr_data[CTL_EN_BIT];
        hs_mode <= wr_data[CTL_HS_BIT];
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADR_RELOAD: rd_data = reload;
      ADR_CTRL:   rd_data = {{PAD_W{1'b0}}, hs_mode, irq_en, run};
      ADR_ACK:    rd_data = count;
      default:    rd_data = '0;
    endcase
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run); // R3
  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_SPARE) |=> ($stable(reload) && $stable(run) && $stable(irq_en) && $stable(hs_mode))); // R9
  AST_RELOAD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> (reload == $past(wr_data))); // R2
endmodule

// File: rtl/hbt_counter.sv
module hbt_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         start,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         tc
);
  function automatic logic [W-1:0] step_count(input logic [W-1:0] c,
                                               input logic [W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign tc = run && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (start) count <= reload;
    else if (run)   count <= step_count(count, reload);
  end

  AST_TC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (count == $past(reload))); // R5
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tc && !start) |=> (count == $past(count) - 1'b1)); // R4
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(count)); // R3
endmodule

// File: rtl/hbt_irq.sv
module hbt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic hs_mode,
  input  logic tc,
  input  logic ack,
  output logic irq_n
);
  import hbt_pkg::*;

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next(irq_en, hs_mode, tc, ack, irq_q);
  end

  assign irq_n = ~irq_q;

  AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> irq_n); // R6
  AST_TC_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && irq_en) |=> !irq_n); // R7
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_mode && !tc) |=> irq_n); // R7
  AST_HS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && irq_en && !irq_n && !ack) |=> !irq_n); // R8
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_en) |=> irq_n); // R10
endmodule

// File: rtl/hbt_top.sv
module hbt_top #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_n
);
  logic [CNT_W-1:0] reload_w, count_w;
  logic run_w, en_w, hs_w, start_w, ack_w, tc_w;

  hbt_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .count(count_w),
    .reload(reload_w), .run(run_w), .irq_en(en_w), .hs_mode(hs_w),
    .start(start_w), .ack(ack_w), .rd_data(rd_data)
  );

  hbt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_w), .start(start_w),
    .reload(reload_w), .count(count_w), .tc(tc_w)
  );

  hbt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_en(en_w), .hs_mode(hs_w),
    .tc(tc_w), .ack(ack_w), .irq_n(irq_n)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (irq_n || !rst_n)); // R1
endmodule

// File: tb/sim_hbt_top.sv
`timescale 1ns/1ps
module sim_hbt_top;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] rd_addr = 2'd2;
  logic [W-1:0] rd_data;
  logic irq_n;

  int checks = 0;
  int fails = 0;

  // reference state
  logic [W-1:0] m_count, m_reload;
  logic m_run, m_en, m_hs, m_irq;

  always #2.5 clk = ~clk;

  hbt_top #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic logic [W-1:0] exp_count(input logic [W-1:0] c, input logic [W-1:0] r,
                                             input logic running, input logic starting);
    if (starting) return r;
    if (!running) return c;
    if (c == 0) return r;
    return c - 1;
  endfunction

  function automatic logic exp_irq(input logic hit, input logic acked);
    if (!m_en) return 1'b0;
    if (hit) return 1'b1;
    return m_hs && m_irq && !acked;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_count = '0; m_reload = '0; m_run = 0; m_en = 0; m_hs = 0; m_irq = 0;
  endtask

  // one clock with the given write; checks count and irq after the edge
  task automatic step(input logic we, input logic [1:0] a, input logic [W-1:0] d);
    logic hit, starting, acked;
    string cnt_tag, irq_tag;
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = 2'd2;
    starting = we && a == 2'd1 && d[0] && !m_run;
    acked = we && a == 2'd2;
    hit = m_run && m_count == 0;
    cnt_tag = starting ? "R3" : !m_run ? "R3" : hit ? "R5" : "R4";
    irq_tag = !m_en ? (m_irq ? "R10" : "R6") : (we && a == 2'd3) ? "R9" : m_hs ? "R8" : "R7";
    @(posedge clk);
    m_irq = exp_irq(hit, acked);
    m_count = exp_count(m_count, m_reload, m_run, starting);
    if (we && a == 2'd0) m_reload = d;
    if (we && a == 2'd1) begin m_run = d[0]; m_en = d[1]; m_hs = d[2]; end
    @(negedge clk);
    check(cnt_tag, rd_data, m_count);
    check(irq_tag, {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, ~m_irq});
    wr_en = 1'b0;
  endtask

  task automatic readback(input logic [1:0] a, input logic [W-1:0] exp, input string req);
    rd_addr = a; #1;
    check(req, rd_data, exp);
    rd_addr = 2'd2;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {{(W-1){1'b0}}, irq_n}, 24'd1);
    readback(2'd0, 24'd0, "R1");
    readback(2'd1, 24'd0, "R1");
    readback(2'd2, 24'd0, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 full-width reload
    step(1, 2'd0, 24'hABCDEF);
    readback(2'd0, 24'hABCDEF, "R2");
    step(1, 2'd0, 24'd3);
    readback(2'd0, 24'd3, "R2");

    // pulse mode, enabled, run: R3 R4 R5 R7
    step(1, 2'd1, 24'b011);
    readback(2'd1, 24'b011, "R3");
    repeat (10) step(0, 2'd0, '0);

    // R9 reserved write in mid count
    step(1, 2'd3, 24'hFFFFFF);
    readback(2'd0, 24'd3, "R9");
    readback(2'd1, 24'b011, "R9");
    repeat (4) step(0, 2'd0, '0);

    // reload 0, handshake: every clock a terminal count; ack on tc keeps it low (R8)
    step(1, 2'd0, 24'd0);
    step(1, 2'd1, 24'b111);
    repeat (3) step(0, 2'd0, '0);
    step(1, 2'd2, 24'd0);
    step(1, 2'd2, 24'd0);
    // R10 disable releases
    step(1, 2'd1, 24'b101);
    step(0, 2'd0, '0);
    // handshake hold then ack with longer interval
    step(1, 2'd0, 24'd5);
    step(1, 2'd1, 24'b110);
    step(1, 2'd1, 24'b111);
    repeat (12) step(0, 2'd0, '0);
    step(1, 2'd2, 24'd0);
    repeat (3) step(0, 2'd0, '0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4)       step(1, 2'd0, 24'($urandom_range(0, 12)));
      else if (r < 9)  step(1, 2'd1, 24'($urandom_range(0, 7)));
      else if (r < 16) step(1, 2'd2, 24'($urandom));
      else if (r < 19) step(1, 2'd3, 24'($urandom));
      else             step(0, 2'd0, '0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule